// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block counts ticks from a 10 Hz time base and raises an interrupt request once a chosen delay has passed. A 3-bit code picks one of seven delays, from a tenth of a second up to one minute. Code zero switches the timer off. A mode bit sets one of two behaviours: the timer fires once and then waits, or it fires on a fixed period. The request stays pending until the host reads the control register, which the surrounding logic signals with a one-cycle read pulse. The pad is modelled as an output level plus an output enable. In normal operation the pin is only ever pulled low.

A test-mode bit hands the pin to the oscillator clock for trimming the crystal. The pin then drives the buffered oscillator level in both directions. Timekeeping goes on in the background, and a request that becomes pending during test mode shows on the pin once test mode ends. Any change to the delay code or the mode bit counts as reprogramming, and the count restarts from zero.

Top module: `pit_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the pending request is cleared and the count restarts; after reset with `test_mode` low, `irq_oe` is 0.
- R2: Codes 1 to 7 on `delay_sel` select 1, 5, 10, 50, 100, 300 and 600 ticks. The request becomes pending in the cycle after the clock edge that samples the last of that many ticks counted since (re)programming.
- R3: With `delay_sel` = 0 no request is ever raised.
- R4: With `test_mode` low, `irq_n` is 0 and `irq_oe` equals the pending request (1 = pin pulled low).
- R5: A `ctrl_rd` pulse clears the pending request at the next edge, unless an expiry happens in that same cycle.
- R6: When an expiry and `ctrl_rd` fall in the same cycle, the request stays pending.
- R7: With `repeat_en` = 1 the count reloads on every expiry, so expiries are exactly the selected number of ticks apart, whenever the read happens.
- R8: With `repeat_en` = 0 the timer stops after one expiry and stays stopped until `delay_sel` or `repeat_en` changes.
- R9: A change of `delay_sel` or `repeat_en` restarts the count from zero. A tick sampled in the same cycle as the change is not counted.
- R10: With `test_mode` high, `irq_oe` is 1 and `irq_n` follows `osc_in`. Counting and the pending state go on unchanged and show once `test_mode` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_10hz | input | 1 | One-cycle pulse at 10 Hz |
| osc_in | input | 1 | Oscillator level, sent to the pin in test mode |
| delay_sel | input | 3 | Delay code; 0 = off, 1..7 = ascending delays |
| repeat_en | input | 1 | 1 = periodic, 0 = single shot |
| ctrl_rd | input | 1 | One-cycle pulse when the control register is read |
| test_mode | input | 1 | Routes the oscillator onto the pin |
| irq_n | output | 1 | Pin level when driven |
| irq_oe | output | 1 | Pin drive enable |

## Verification
Two events can land in the same clock cycle: an expiry of the tick counter, and the clear caused by a control-register read. The bench sets this up on purpose. It uses the one-tick delay in periodic mode and asserts `ctrl_rd` together with a tick, then checks that the request is still pending one cycle later. It then reads again without a tick and checks that the request clears. The random phase also puts reads next to ticks at random, and a cycle-level model built from the requirements judges every one of those collisions.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int SEL_W     = 3;
    localparam int MAX_TICKS = 600;
    localparam int CNT_W     = $clog2(MAX_TICKS);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        sel_t sel;
        logic rpt;
    } cfg_t;

    // last count value before expiry for each delay code
    function automatic cnt_t last_count(input sel_t s);
        case (s)
            3'd1:    return cnt_t'(0);
            3'd2:    return cnt_t'(4);
            3'd3:    return cnt_t'(9);
            3'd4:    return cnt_t'(49);
            3'd5:    return cnt_t'(99);
            3'd6:    return cnt_t'(299);
            3'd7:    return cnt_t'(MAX_TICKS - 1);
            default: return cnt_t'(0);
        endcase
    endfunction

    function automatic logic sel_active(input sel_t s);
        return s != '0;
    endfunction
endpackage

// File: rtl/pit_cfg_track.sv
module pit_cfg_track
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    output cfg_t cfg_q,
    output logic reprog
);
    assign reprog = (cfg_in != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (reprog) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/pit_countdown.sv
module pit_countdown
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic reprog,
    input  cfg_t cfg_q,
    output logic expire,
    output cnt_t cnt,
    output cnt_t term
);
    logic armed;
    logic counting;

    always_comb begin
        term     = last_count(cfg_q.sel);
        counting = !reprog && armed && sel_active(cfg_q.sel) && tick;
        expire   = counting && (cnt == term);
    end

    always_ff @(posedge clk) begin
        if (rst || reprog) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (counting) begin
            if (cnt == term) begin
                cnt   <= '0;
                armed <= cfg_q.rpt;
            end else begin
                cnt <= cnt + cnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/pit_irq_out.sv
module pit_irq_out (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ctrl_rd,
    input  logic test_mode,
    input  logic osc_in,
    output logic pend,
    output logic irq_n,
    output logic irq_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (expire) begin
            pend <= 1'b1;
        end else if (ctrl_rd) begin
            pend <= 1'b0;
        end
    end

    always_comb begin
        if (test_mode) begin
            irq_oe = 1'b1;
            irq_n  = osc_in;
        end else begin
            irq_oe = pend;
            irq_n  = 1'b0;
        end
    end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_10hz,
    input  logic             osc_in,
    input  logic [SEL_W-1:0] delay_sel,
    input  logic             repeat_en,
    input  logic             ctrl_rd,
    input  logic             test_mode,
    output logic             irq_n,
    output logic             irq_oe
);
    cfg_t cfg_in;
    cfg_t cfg_q;
    logic reprog;
    logic expire;
    logic pend_q;
    cnt_t cnt_q;
    cnt_t term_val;

    assign cfg_in = '{sel: delay_sel, rpt: repeat_en};

    pit_cfg_track u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .reprog (reprog)
    );

    pit_countdown u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_10hz),
        .reprog (reprog),
        .cfg_q  (cfg_q),
        .expire (expire),
        .cnt    (cnt_q),
        .term   (term_val)
    );

    pit_irq_out u_out (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .ctrl_rd   (ctrl_rd),
        .test_mode (test_mode),
        .osc_in    (osc_in),
        .pend      (pend_q),
        .irq_n     (irq_n),
        .irq_oe    (irq_oe)
    );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_10hz,
    input logic       ctrl_rd,
    input logic [2:0] delay_sel,
    input logic       test_mode,
    input logic       irq_n,
    input logic       irq_oe,
    input logic       pend,
    input cnt_t       cnt,
    input cnt_t       term
);
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> !pend);

    p_set_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!pend && !tick_10hz) |=> !pend);

    p_zero_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (!pend && delay_sel == 3'd0) |=> !pend);

    p_drive_low_only_r4: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> !irq_n);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd && !tick_10hz) |=> !pend);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= term);

    p_test_drives_r10: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> irq_oe);
endmodule

bind pit_timer pit_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_10hz (tick_10hz),
    .ctrl_rd   (ctrl_rd),
    .delay_sel (delay_sel),
    .test_mode (test_mode),
    .irq_n     (irq_n),
    .irq_oe    (irq_oe),
    .pend      (pend_q),
    .cnt       (cnt_q),
    .term      (term_val)
);

// File: tb/pit_timer_test.sv
module pit_timer_test;
    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_10hz = 1'b0;
    logic       osc_in = 1'b0;
    logic [2:0] delay_sel = 3'd0;
    logic       repeat_en = 1'b0;
    logic       ctrl_rd = 1'b0;
    logic       test_mode = 1'b0;
    logic       irq_n;
    logic       irq_oe;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic [2:0] m_sel = 3'd0;
    logic       m_rpt = 1'b0;
    int         m_cnt = 0;
    logic       m_armed = 1'b1;
    logic       m_pend = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    pit_timer uut (
        .clk       (clk),
        .rst       (rst),
        .tick_10hz (tick_10hz),
        .osc_in    (osc_in),
        .delay_sel (delay_sel),
        .repeat_en (repeat_en),
        .ctrl_rd   (ctrl_rd),
        .test_mode (test_mode),
        .irq_n     (irq_n),
        .irq_oe    (irq_oe)
    );

    function automatic int delay_ticks(input logic [2:0] s);
        case (s)
            3'd1: return 1;
            3'd2: return 5;
            3'd3: return 10;
            3'd4: return 50;
            3'd5: return 100;
            3'd6: return 300;
            3'd7: return 600;
            default: return 0;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic model_update();
        logic expd;
        expd = 1'b0;
        if (rst) begin
            m_sel = 3'd0; m_rpt = 1'b0; m_cnt = 0; m_armed = 1'b1; m_pend = 1'b0;
        end else begin
            if (delay_sel != m_sel || repeat_en != m_rpt) begin
                m_sel = delay_sel; m_rpt = repeat_en; m_cnt = 0; m_armed = 1'b1;
            end else if (m_armed && m_sel != 3'd0 && tick_10hz) begin
                if (m_cnt == delay_ticks(m_sel) - 1) begin
                    expd = 1'b1; m_cnt = 0; m_armed = m_rpt;
                end else begin
                    m_cnt++;
                end
            end
            if (expd) m_pend = 1'b1;
            else if (ctrl_rd) m_pend = 1'b0;
        end
    endtask

    // called at a falling edge; applies one cycle and compares at the next falling edge
    task automatic step(input logic tk, input logic rd);
        tick_10hz = tk;
        ctrl_rd   = rd;
        @(posedge clk);
        model_update();
        @(negedge clk);
        tick_10hz = 1'b0;
        ctrl_rd   = 1'b0;
        check(irq_oe === (test_mode ? 1'b1 : m_pend), "R4/R10 irq_oe vs model", int'(irq_oe),
              int'(test_mode ? 1'b1 : m_pend));
        check(irq_n === (test_mode ? osc_in : 1'b0), "R4/R10 irq_n vs model", int'(irq_n),
              int'(test_mode ? osc_in : 1'b0));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h1f2e3d4c));
        @(negedge clk);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        rst = 1'b0;
        // R1: nothing pending after reset
        check(irq_oe == 1'b0, "R1 reset irq_oe", int'(irq_oe), 0);

        // R2 / R8: single shot, 5 ticks
        delay_sel = 3'd2; repeat_en = 1'b0;
        step(1'b0, 1'b0);
        ticks(4);
        check(irq_oe == 1'b0, "R2 before 5th tick", int'(irq_oe), 0);
        ticks(1);
        check(irq_oe == 1'b1, "R2 after 5th tick", int'(irq_oe), 1);
        check(irq_n == 1'b0, "R4 pin pulled low", int'(irq_n), 0);
        step(1'b0, 1'b1);
        check(irq_oe == 1'b0, "R5 read clears", int'(irq_oe), 1'b0);
        ticks(12);
        check(irq_oe == 1'b0, "R8 single shot stopped", int'(irq_oe), 0);

        // R8 / R7: reprogram to repeat
        repeat_en = 1'b1;
        step(1'b0, 1'b0);
        ticks(5);
        check(irq_oe == 1'b1, "R8 rearmed by reprogram", int'(irq_oe), 1);
        ticks(2);
        step(1'b0, 1'b1);
        ticks(2);
        check(irq_oe == 1'b0, "R7 no early expiry", int'(irq_oe), 0);
        ticks(1);
        check(irq_oe == 1'b1, "R7 period independent of read", int'(irq_oe), 1);

        // R6: expiry and read together
        delay_sel = 3'd1;
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        check(irq_oe == 1'b1, "R2 one-tick delay", int'(irq_oe), 1);
        step(1'b1, 1'b1);
        check(irq_oe == 1'b1, "R6 set wins over read", int'(irq_oe), 1);
        step(1'b0, 1'b1);
        check(irq_oe == 1'b0, "R5 read without tick clears", int'(irq_oe), 0);

        // R3: code zero never fires
        delay_sel = 3'd0;
        step(1'b0, 1'b0);
        ticks(700);
        check(irq_oe == 1'b0, "R3 code zero silent", int'(irq_oe), 0);

        // R9: tick in the reprogram cycle is ignored
        delay_sel = 3'd3; repeat_en = 1'b0;
        step(1'b0, 1'b0);
        ticks(7);
        delay_sel = 3'd2;
        step(1'b1, 1'b0);
        ticks(4);
        check(irq_oe == 1'b0, "R9 restart, 4 ticks", int'(irq_oe), 0);
        ticks(1);
        check(irq_oe == 1'b1, "R9 restart, 5 ticks", int'(irq_oe), 1);
        step(1'b0, 1'b1);

        // R10: test mode
        test_mode = 1'b1; delay_sel = 3'd1; osc_in = 1'b0;
        step(1'b0, 1'b0);
        check(irq_oe == 1'b1 && irq_n == 1'b0, "R10 test osc low", int'(irq_n), 0);
        osc_in = 1'b1;
        step(1'b1, 1'b0);
        check(irq_oe == 1'b1 && irq_n == 1'b1, "R10 test osc high", int'(irq_n), 1);
        test_mode = 1'b0;
        step(1'b0, 1'b0);
        check(irq_oe == 1'b1, "R10 pending kept through test", int'(irq_oe), 1);

        // R2 long delay: code 7
        step(1'b0, 1'b1);
        delay_sel = 3'd7;
        step(1'b0, 1'b0);
        ticks(599);
        check(irq_oe == 1'b0, "R2 code 7 at 599", int'(irq_oe), 0);
        ticks(1);
        check(irq_oe == 1'b1, "R2 code 7 at 600", int'(irq_oe), 1);

        // random phase checked against the model
        for (int i = 0; i < 6000; i++) begin
            logic tk;
            logic rd;
            if ($urandom_range(199) == 0) delay_sel = 3'($urandom_range(4));
            if ($urandom_range(149) == 0) repeat_en = ~repeat_en;
            if ($urandom_range(299) == 0) test_mode = ~test_mode;
            osc_in = 1'($urandom_range(1));
            tk = ($urandom_range(3) == 0);
            rd = ($urandom_range(9) == 0);
            step(tk, rd);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule